// File: doc/BRIEF.md
# Packed-BCD Capable 8-bit Arithmetic and Logic Unit

This block is the data path ALU of an 8-bit accumulator machine. Each cycle it receives an accumulator value, an operand, a 4-bit operation code and the current 8-bit status word. It returns a result byte and a new status word in which the negative, overflow, zero and carry flags have been updated. The other status bits pass through unchanged.

Add and subtract switch to packed two-digit BCD arithmetic when the decimal flag is set. Each nibble is corrected by 6 on its own. In this mode the overflow flag of an add is taken from the high digit before that digit is corrected, and negative and zero follow the plain binary result. Compare, the logic operations, increment and decrement, the four shift and rotate forms, and bit test complete the set. Register storage, operand fetch and sequencing belong to the surrounding core.

The logic is combinational. The parameter `REG_OUT` places a register on both outputs (default 1), so results appear one clock after their inputs.

Top module: `bcd_alu8`

## Requirements
- R1: Code 0 (add), decimal flag (status bit 3) clear: the result is A+M+C mod 256, where C is status bit 0. The new C is the carry out of bit 7. V (bit 6) is set when A and M have the same sign and the result's sign differs from it. N (bit 7) is result bit 7. Z (bit 1) is set when the result is zero.
- R2: Code 1 (subtract), decimal flag clear: the result is A−M−(1−C). The new C is 1 when no borrow occurred and 0 otherwise. V is bit 7 of (A^M)&(A^result). N and Z follow the result.
- R3: Code 0 with the decimal flag set: the low sum is low(A)+low(M)+C, and 6 is added to it when it exceeds 9. The high sum is high(A)+high(M), plus 1 when the adjusted low sum exceeds 15. 6 is added to the high sum when it exceeds 9. The new C is set when the adjusted high sum exceeds 15. The result is {high[3:0], low[3:0]}.
- R4: In a decimal add, V is bit 7 of ~(A^M)&(A^(uncorrected high sum shifted into bits 7:4)). In a decimal add or subtract, N and Z come from the binary result of the same operation, not from the corrected result.
- R5: Code 1 with the decimal flag set: the low digit difference is low(A)−low(M)−(1−C). When it is negative, 6 is subtracted from it and 1 is borrowed from the high digit. 6 is also subtracted from the high digit difference when that is negative. C and V are as in R2.
- R6: Code 2 (compare): the result equals A. N and Z come from A−M. C is set when A ≥ M (unsigned). V is unchanged. The decimal flag is ignored.
- R7: Codes 3 (OR), 4 (AND) and 5 (XOR) combine A with M. N and Z follow the result. V and C are unchanged.
- R8: Codes 6 (increment) and 7 (decrement) act on M and wrap modulo 256. N and Z follow the result. V and C are unchanged.
- R9: Codes 8 to 11 act on M. Code 8 shifts left and code 9 shifts right. Code 10 rotates left through C and code 11 rotates right through C. The new C is the bit shifted out. N and Z follow the result, and V is unchanged.
- R10: Code 12 (bit test): the result equals A. N takes M bit 7 and V takes M bit 6. Z is set when A&M is zero. C is unchanged.
- R11: Output status bit 5 is always 1. Output bits 4, 3 and 2 equal the input status bits 4, 3 and 2.
- R12: Codes 13 to 15 return A unchanged and the input status word with bit 5 set.
- R13: With REG_OUT=1, both outputs are registered one clock after their inputs. While rst_n is low they read result 0x00 and status 0x20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code (see requirements) |
| acc_i | input | 8 | Accumulator operand A |
| opd_i | input | 8 | Second operand M |
| stat_i | input | 8 | Current status word |
| res_o | output | 8 | Result byte |
| stat_o | output | 8 | Updated status word |

## Verification
With the default output register, every result and every flag is due exactly one rising edge after its inputs settle, and nothing is due later than that. The bench drives each vector just after a falling edge and compares both outputs at the next falling edge. This sits half a period after the edge that captured them. A separate latency check samples just before the capturing edge and confirms the outputs still hold the previous vector's values there. The assertions compare the outputs against copies of the inputs taken one register stage earlier, so they line up with that same one-cycle delay.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_OR  = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_INC = 4'd6,
    OP_DEC = 4'd7,
    OP_SHL = 4'd8,
    OP_SHR = 4'd9,
    OP_RTL = 4'd10,
    OP_RTR = 4'd11,
    OP_TST = 4'd12
  } alu_op_e;

  localparam int SW     = 8;
  localparam int FL_NEG = 7;
  localparam int FL_OVF = 6;
  localparam int FL_RSV = 5;
  localparam int FL_DEC = 3;
  localparam int FL_ZER = 1;
  localparam int FL_CRY = 0;
endpackage

// File: rtl/bcd_alu_digit.sv
module bcd_alu_digit (
  input  logic       sub_i,
  input  logic [3:0] a_i,
  input  logic [3:0] m_i,
  input  logic       cy_i,   // add: carry in; sub: 1 = no borrow in
  output logic [3:0] dig_o,
  output logic       ovf_o,  // sign overflow of the uncorrected digit sum
  output logic       cy_o
);
  logic [5:0] raw;
  logic [5:0] adj;

  always_comb begin
    if (sub_i) begin
      raw  = {2'b00, a_i} - {2'b00, m_i} - {5'd0, ~cy_i};
      adj  = raw[5] ? (raw - 6'd6) : raw;
      cy_o = ~raw[5];
    end else begin
      raw  = {2'b00, a_i} + {2'b00, m_i} + {5'd0, cy_i};
      adj  = (raw > 6'd9) ? (raw + 6'd6) : raw;
      cy_o = (adj > 6'd15);
    end
  end

  assign dig_o = adj[3:0];
  assign ovf_o = (a_i[3] == m_i[3]) && (a_i[3] != raw[3]);
endmodule

// File: rtl/bcd_alu_arith.sv
module bcd_alu_arith #(
  parameter int DW = 8
) (
  input  logic          sub_i,
  input  logic          dec_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          n_o,
  output logic          v_o,
  output logic          z_o,
  output logic          c_o
);
  localparam int ND = DW / 4;
  localparam logic [ND-1:0] TOPSEL = ND'(1) << (ND - 1);

  logic [DW-1:0] b;
  logic [DW:0]   ext;
  logic          bin_v;
  logic [ND:0]   cy;
  logic [ND-1:0] dov;
  logic [DW-1:0] dres;
  logic          dec_add;

  assign b     = sub_i ? ~m_i : m_i;
  assign ext   = {1'b0, a_i} + {1'b0, b} + {{DW{1'b0}}, cin_i};
  assign bin_v = (a_i[DW-1] == b[DW-1]) && (ext[DW-1] != a_i[DW-1]);

  assign cy[0] = cin_i;
  for (genvar g = 0; g < ND; g++) begin : g_dig
    bcd_alu_digit u_dig (
      .sub_i (sub_i),
      .a_i   (a_i[4*g +: 4]),
      .m_i   (m_i[4*g +: 4]),
      .cy_i  (cy[g]),
      .dig_o (dres[4*g +: 4]),
      .ovf_o (dov[g]),
      .cy_o  (cy[g+1])
    );
  end

  assign dec_add = dec_i && !sub_i;
  assign res_o   = dec_i ? dres : ext[DW-1:0];
  assign n_o     = ext[DW-1];
  assign z_o     = (ext[DW-1:0] == '0);
  assign v_o     = dec_add ? |(dov & TOPSEL) : bin_v;
  assign c_o     = dec_add ? cy[ND] : ext[DW];
endmodule

// File: rtl/bcd_alu_unit.sv
module bcd_alu_unit #(
  parameter int DW = 8
) (
  input  bcd_alu_pkg::alu_op_e op_i,
  input  logic [DW-1:0]        a_i,
  input  logic [DW-1:0]        m_i,
  input  logic                 cin_i,
  input  logic                 vin_i,
  output logic [DW-1:0]        res_o,
  output logic                 n_o,
  output logic                 v_o,
  output logic                 z_o,
  output logic                 c_o
);
  import bcd_alu_pkg::*;

  always_comb begin
    res_o = a_i;
    v_o   = vin_i;
    c_o   = cin_i;
    unique case (op_i)
      OP_OR:  res_o = a_i | m_i;
      OP_AND: res_o = a_i & m_i;
      OP_XOR: res_o = a_i ^ m_i;
      OP_INC: res_o = m_i + 1'b1;
      OP_DEC: res_o = m_i - 1'b1;
      OP_SHL: {c_o, res_o} = {m_i, 1'b0};
      OP_SHR: {res_o, c_o} = {1'b0, m_i};
      OP_RTL: {c_o, res_o} = {m_i, cin_i};
      OP_RTR: {res_o, c_o} = {cin_i, m_i};
      OP_TST: v_o = m_i[DW-2];
      default: ;
    endcase
    if (op_i == OP_TST) begin
      n_o = m_i[DW-1];
      z_o = ((a_i & m_i) == '0);
    end else begin
      n_o = res_o[DW-1];
      z_o = (res_o == '0);
    end
  end
endmodule

// File: rtl/bcd_alu8.sv
module bcd_alu8 #(
  parameter int DW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opd_i,
  input  logic [7:0]    stat_i,
  output logic [DW-1:0] res_o,
  output logic [7:0]    stat_o
);
  import bcd_alu_pkg::*;

  localparam logic [SW-1:0] ST_RST = SW'(1) << FL_RSV;

  alu_op_e       op;
  logic          is_cmp;
  logic [DW-1:0] ar_res, lu_res, res_d;
  logic          ar_n, ar_v, ar_z, ar_c;
  logic          lu_n, lu_v, lu_z, lu_c;
  logic [SW-1:0] st_d;

  assign op     = alu_op_e'(op_i);
  assign is_cmp = (op == OP_CMP);

  bcd_alu_arith #(.DW(DW)) u_arith (
    .sub_i (op != OP_ADD),
    .dec_i (stat_i[FL_DEC] && !is_cmp),
    .a_i   (acc_i),
    .m_i   (opd_i),
    .cin_i (is_cmp ? 1'b1 : stat_i[FL_CRY]),
    .res_o (ar_res),
    .n_o   (ar_n),
    .v_o   (ar_v),
    .z_o   (ar_z),
    .c_o   (ar_c)
  );

  bcd_alu_unit #(.DW(DW)) u_unit (
    .op_i  (op),
    .a_i   (acc_i),
    .m_i   (opd_i),
    .cin_i (stat_i[FL_CRY]),
    .vin_i (stat_i[FL_OVF]),
    .res_o (lu_res),
    .n_o   (lu_n),
    .v_o   (lu_v),
    .z_o   (lu_z),
    .c_o   (lu_c)
  );

  // next-state selection
  always_comb begin
    res_d          = acc_i;
    st_d           = stat_i;
    st_d[FL_RSV]   = 1'b1;
    unique case (op)
      OP_ADD, OP_SUB: begin
        res_d      = ar_res;
        st_d[FL_NEG] = ar_n;
        st_d[FL_OVF] = ar_v;
        st_d[FL_ZER] = ar_z;
        st_d[FL_CRY] = ar_c;
      end
      OP_CMP: begin
        st_d[FL_NEG] = ar_n;
        st_d[FL_ZER] = ar_z;
        st_d[FL_CRY] = ar_c;
      end
      OP_OR, OP_AND, OP_XOR, OP_INC, OP_DEC,
      OP_SHL, OP_SHR, OP_RTL, OP_RTR, OP_TST: begin
        res_d      = lu_res;
        st_d[FL_NEG] = lu_n;
        st_d[FL_OVF] = lu_v;
        st_d[FL_ZER] = lu_z;
        st_d[FL_CRY] = lu_c;
      end
      default: ;
    endcase
  end

  if (REG_OUT) begin : g_reg
    logic [DW-1:0] res_q;
    logic [SW-1:0] st_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
        st_q  <= ST_RST;
      end else begin
        res_q <= res_d;
        st_q  <= st_d;
      end
    end
    assign res_o  = res_q;
    assign stat_o = st_q;
  end else begin : g_comb
    assign res_o  = res_d;
    assign stat_o = st_d;
  end
endmodule

// File: rtl/bcd_alu8_chk.sv
module bcd_alu8_chk #(
  parameter int DW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    op_i,
  input logic [DW-1:0] acc_i,
  input logic [DW-1:0] opd_i,
  input logic [7:0]    stat_i,
  input logic [DW-1:0] res_o,
  input logic [7:0]    stat_o
);
  logic [3:0]    q_op;
  logic [DW-1:0] q_acc, q_opd;
  logic [7:0]    q_st;
  logic          primed;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_op   <= '0;
        q_acc  <= '0;
        q_opd  <= '0;
        q_st   <= '0;
        primed <= 1'b0;
      end else begin
        q_op   <= op_i;
        q_acc  <= acc_i;
        q_opd  <= opd_i;
        q_st   <= stat_i;
        primed <= 1'b1;
      end
    end
  end else begin : g_now
    assign q_op   = op_i;
    assign q_acc  = acc_i;
    assign q_opd  = opd_i;
    assign q_st   = stat_i;
    assign primed = 1'b1;
  end

  p_status_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (stat_o[5] && stat_o[4:2] == q_st[4:2]));

  p_logic_keeps_vc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && q_op >= 4'd3 && q_op <= 4'd5) |->
      (stat_o[6] == q_st[6] && stat_o[0] == q_st[0]));

  p_cmp_keeps_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && q_op == 4'd2) |-> (res_o == q_acc && stat_o[6] == q_st[6]));

  p_test_copies_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && q_op == 4'd12) |->
      (res_o == q_acc && stat_o[7] == q_opd[DW-1] && stat_o[6] == q_opd[DW-2]
       && stat_o[0] == q_st[0]));

  p_spare_codes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && q_op >= 4'd13) |-> (res_o == q_acc && stat_o == (q_st | 8'h20)));

  p_incdec_keeps_vc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && (q_op == 4'd6 || q_op == 4'd7)) |->
      (stat_o[6] == q_st[6] && stat_o[0] == q_st[0] && stat_o[1] == (res_o == '0)));
endmodule

bind bcd_alu8 bcd_alu8_chk #(.DW(DW), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_bcd_alu8.sv
module sim_bcd_alu8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [3:0] op_i = 4'd0;
  logic [7:0] acc_i = 8'd0, opd_i = 8'd0, stat_i = 8'd0;
  logic [7:0] res_o, stat_o;
  int         n_chk = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  bcd_alu8 u0 (.clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i),
               .opd_i(opd_i), .stat_i(stat_i), .res_o(res_o), .stat_o(stat_o));

  // reference built from the requirement text
  function automatic void model(input logic [3:0] op, input logic [7:0] a, m, st,
                                output logic [7:0] r, output logic [7:0] so);
    int s, lo, hi, lu, ci;
    bit nzset;
    ci = int'(st[0]);
    so = st | 8'h20;
    r = a;
    nzset = 1'b1;
    case (op)
      4'd0: begin
        s = int'(a) + int'(m) + ci;
        so[6] = ((~(a ^ m)) & (a ^ 8'(s)) & 8'h80) != 0;
        so[0] = s > 255;
        r = 8'(s);
        if (st[3]) begin
          lo = (a & 15) + (m & 15) + ci;
          if (lo > 9) lo += 6;
          hi = (a >> 4) + (m >> 4) + ((lo > 15) ? 1 : 0);
          so[6] = ((~(a ^ m)) & (a ^ 8'(hi << 4)) & 8'h80) != 0;
          if (hi > 9) hi += 6;
          so[0] = hi > 15;
          r = 8'(((hi & 15) << 4) | (lo & 15));
        end
        so[7] = s[7]; so[1] = (s & 255) == 0; nzset = 1'b0;
      end
      4'd1: begin
        s = int'(a) - int'(m) - (1 - ci);
        so[6] = ((a ^ m) & (a ^ 8'(s)) & 8'h80) != 0;
        so[0] = s >= 0;
        r = 8'(s);
        if (st[3]) begin
          lo = (a & 15) - (m & 15) - (1 - ci);
          lu = (lo < 0) ? 1 : 0;
          if (lu != 0) lo -= 6;
          hi = (a >> 4) - (m >> 4) - lu;
          if (hi < 0) hi -= 6;
          r = 8'(((hi & 15) << 4) | (lo & 15));
        end
        so[7] = s[7]; so[1] = (s & 255) == 0; nzset = 1'b0;
      end
      4'd2: begin
        s = int'(a) - int'(m);
        so[7] = s[7]; so[1] = (s & 255) == 0; so[0] = s >= 0; nzset = 1'b0;
      end
      4'd3: r = a | m;
      4'd4: r = a & m;
      4'd5: r = a ^ m;
      4'd6: r = m + 8'd1;
      4'd7: r = m - 8'd1;
      4'd8: begin r = {m[6:0], 1'b0}; so[0] = m[7]; end
      4'd9: begin r = {1'b0, m[7:1]}; so[0] = m[0]; end
      4'd10: begin r = {m[6:0], st[0]}; so[0] = m[7]; end
      4'd11: begin r = {st[0], m[7:1]}; so[0] = m[0]; end
      4'd12: begin
        so[7] = m[7]; so[6] = m[6]; so[1] = (a & m) == 0; nzset = 1'b0;
      end
      default: nzset = 1'b0;
    endcase
    if (nzset) begin
      so[7] = r[7];
      so[1] = (r == 0);
    end
  endfunction

  task automatic check(input string tag, input logic [7:0] gr, gs, er, es);
    n_chk++;
    if (gr !== er || gs !== es) begin
      n_bad++;
      $display("FAIL %s: res=%h stat=%h, expected res=%h stat=%h", tag, gr, gs, er, es);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [7:0] a, m, st);
    @(negedge clk);
    op_i = op; acc_i = a; opd_i = m; stat_i = st;
    @(negedge clk);
  endtask

  // golden value plus model cross-check
  task automatic gold(input string tag, input logic [3:0] op, input logic [7:0] a, m, st,
                      input logic [7:0] er, es);
    logic [7:0] mr, ms;
    drive(op, a, m, st);
    check(tag, res_o, stat_o, er, es);
    model(op, a, m, st, mr, ms);
    check({tag, " model"}, res_o, stat_o, mr, ms);
  endtask

  task automatic sweep(input string tag, input logic [3:0] op, input logic [7:0] stmask, input int n);
    logic [7:0] mr, ms, a, m, st;
    for (int i = 0; i < n; i++) begin
      a = 8'($urandom); m = 8'($urandom); st = 8'($urandom) & stmask;
      drive(op, a, m, st);
      model(op, a, m, st, mr, ms);
      check(tag, res_o, stat_o, mr, ms);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    #1;
    check("R13 reset", res_o, stat_o, 8'h00, 8'h20);
    repeat (2) @(posedge clk);
    #1;
    check("R13 reset held", res_o, stat_o, 8'h00, 8'h20);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_bin_add;
    gold("R1 add 50+50", 4'd0, 8'h50, 8'h50, 8'h00, 8'hA0, 8'hE0);
    gold("R1 add ff+01", 4'd0, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h23);
    sweep("R1 add sweep", 4'd0, 8'hF7, 300);
  endtask

  task automatic t_bin_sub;
    gold("R2 sub 80-01", 4'd1, 8'h80, 8'h01, 8'h01, 8'h7F, 8'h61);
    gold("R2 sub borrow", 4'd1, 8'h05, 8'h05, 8'h00, 8'hFF, 8'hA0);
    sweep("R2 sub sweep", 4'd1, 8'hF7, 300);
  endtask

  task automatic t_dec_add;
    gold("R3 dadd 58+46+1", 4'd0, 8'h58, 8'h46, 8'h09, 8'h05, 8'hE9);
    gold("R4 dadd 99+01 nz binary", 4'd0, 8'h99, 8'h01, 8'h08, 8'h00, 8'hA9);
    sweep("R3 dadd sweep", 4'd0, 8'hFF, 400);
  endtask

  task automatic t_dec_sub;
    gold("R5 dsub 50-01", 4'd1, 8'h50, 8'h01, 8'h09, 8'h49, 8'h29);
    gold("R5 dsub 00-01", 4'd1, 8'h00, 8'h01, 8'h09, 8'h99, 8'hA8);
    sweep("R5 dsub sweep", 4'd1, 8'hFF, 400);
  endtask

  task automatic t_cmp;
    gold("R6 cmp equal", 4'd2, 8'h10, 8'h10, 8'h48, 8'h10, 8'h6B);
    gold("R6 cmp less", 4'd2, 8'h10, 8'h20, 8'h01, 8'h10, 8'hA0);
    sweep("R6 cmp sweep", 4'd2, 8'hFF, 200);
  endtask

  task automatic t_logic;
    gold("R7 and zero", 4'd4, 8'hF0, 8'h0F, 8'h41, 8'h00, 8'h63);
    gold("R7 or", 4'd3, 8'h81, 8'h02, 8'h00, 8'h83, 8'hA0);
    gold("R7 xor", 4'd5, 8'hFF, 8'h0F, 8'h41, 8'hF0, 8'hE1);
    sweep("R7 logic sweep", 4'd5, 8'hFF, 100);
  endtask

  task automatic t_incdec;
    gold("R8 inc wrap", 4'd6, 8'h33, 8'hFF, 8'h00, 8'h00, 8'h22);
    gold("R8 dec wrap", 4'd7, 8'h33, 8'h00, 8'h41, 8'hFF, 8'hE1);
    sweep("R8 inc sweep", 4'd6, 8'hFF, 100);
  endtask

  task automatic t_shift;
    gold("R9 shl", 4'd8, 8'h00, 8'h81, 8'h00, 8'h02, 8'h21);
    gold("R9 shr zero", 4'd9, 8'h00, 8'h01, 8'h00, 8'h00, 8'h23);
    gold("R9 rtl", 4'd10, 8'h00, 8'h80, 8'h01, 8'h01, 8'h21);
    gold("R9 rtr", 4'd11, 8'h00, 8'h01, 8'h01, 8'h80, 8'hA1);
    sweep("R9 rtr sweep", 4'd11, 8'hFF, 100);
  endtask

  task automatic t_bit;
    gold("R10 bit test", 4'd12, 8'h0F, 8'hC0, 8'h01, 8'h0F, 8'hE3);
    sweep("R10 bit sweep", 4'd12, 8'hFF, 100);
  endtask

  task automatic t_status;
    gold("R11 flags pass", 4'd3, 8'h01, 8'h00, 8'h1C, 8'h01, 8'h3C);
    gold("R12 spare code", 4'd14, 8'h5A, 8'h77, 8'h1C, 8'h5A, 8'h3C);
    sweep("R12 spare sweep", 4'd15, 8'hFF, 50);
  endtask

  task automatic t_latency;
    drive(4'd3, 8'h11, 8'h00, 8'h00);
    @(negedge clk);
    op_i = 4'd3; acc_i = 8'h22; opd_i = 8'h00; stat_i = 8'h00;
    @(posedge clk);
    #0;
    check("R13 old value before edge", res_o, stat_o, 8'h11, 8'h20);
    @(negedge clk);
    check("R13 new value after edge", res_o, stat_o, 8'h22, 8'h20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: res=%h stat=%h, expected completion", res_o, stat_o);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_bin_add();
    t_bin_sub();
    t_dec_add();
    t_dec_sub();
    t_cmp();
    t_logic();
    t_incdec();
    t_shift();
    t_bit();
    t_status();
    t_latency();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule